// File: doc/BRIEF.md
# Power-Fail Status and Time-Save Controller

This block watches the health of the supply and the oscillator for a battery-backed real-time clock. It holds the flags that software reads after a restart and it drives the automatic time-save snapshot. The supply good, battery mode, external fail pin and low-battery comparator arrive as digital inputs. A seconds tick paces the debounce that keeps the host locked out after the main supply comes back.

The host writes a one-bit value to one of four small registers, chosen by a two-bit address. While the lockout is high, every host write is dropped. The oscillator-fail flag lets software tell a cold start from a recovery: reset sets it, and only starting the clock clears it. The time-save enable makes the save registers track the live counters. The block clears that enable by itself when the supply moves to the battery, and the strobe delivers one final copy at that moment.

Top module: `pwrfail_timesave`

## Requirements
- R1: After reset: osc_fail=1, clk_run=0, single_supply=1, low_batt=0, irq=0, lockout=1, tsave_en=0, save_strobe=0.
- R2: An accepted write to address 0 loads clk_run with wr_val on the next edge. If wr_val=1, osc_fail also goes to 0 on that edge. osc_fail is never set again without a reset.
- R3: An accepted write to address 1 loads single_supply with wr_val (0 selects battery-backed mode). It leaves osc_fail unchanged.
- R4: low_batt equals on_battery AND batt_low_cmp AND fail_irq_en, registered with one cycle of latency.
- R5: irq is set on the edge after a cycle in which (ext_fail=1 or vcc_good=0) and fail_irq_en=1. It then stays high until an accepted write of 1 to address 3. With fail_irq_en=0 a fail never raises irq.
- R6: lockout is 1 on the edge after any cycle with ext_fail=1 or vcc_good=0, whatever the value of fail_irq_en.
- R7: Once the fail condition is gone, lockout falls after exactly L cycles that carry sec_tick=1, where L = max(debounce_len, 30) and debounce_len is 6 bits wide (so L is at most 63).
- R8: A host write is accepted only when lockout=0. While lockout=1, writes change no register.
- R9: An accepted write to address 2 loads tsave_en with wr_val.
- R10: tsave_en clears on the edge after on_battery rises from 0 to 1. ext_fail does not clear it.
- R11: save_strobe is high in each cycle that follows a cycle in which tsave_en was high. This includes the cycle right after the automatic clear, which is the final snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (initial power-up) |
| sec_tick | input | 1 | One-cycle pulse once per second |
| vcc_good | input | 1 | Main supply within range |
| on_battery | input | 1 | Clock running from the battery supply |
| ext_fail | input | 1 | External power-fail pin, active high |
| batt_low_cmp | input | 1 | Battery below threshold comparator result |
| fail_irq_en | input | 1 | Enables fail interrupt and low-battery detection |
| debounce_len | input | 6 | Lockout hold in seconds, raised to 30 when smaller |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | 0 run, 1 mode, 2 time-save, 3 interrupt clear |
| wr_val | input | 1 | Written bit value |
| osc_fail | output | 1 | Oscillator / timekeeping failed flag |
| clk_run | output | 1 | Clock start bit |
| single_supply | output | 1 | Supply mode bit, 0 = battery-backed |
| low_batt | output | 1 | Low-battery flag |
| irq | output | 1 | Fail interrupt level |
| lockout | output | 1 | Host access locked out |
| tsave_en | output | 1 | Time-save enable state |
| save_strobe | output | 1 | Copy live counters into save registers |

## Verification
The bench goes after the places where a careless design would lose the cold-start flag. One is a mode write of 0. Another is a start write of 0. A third is a start write made while locked out. A wrong design would clear osc_fail on any of these, or accept the write. The bench drives the lockout hold with ticks to the exact cycle, for a short length (raised to 30), a middle one and the maximum. An off-by-one counter or a missing clamp would release the lockout one cycle early or late. It asserts ext_fail while the time-save is on, which a wrong design would use to clear tsave_en. It checks that the battery switch yields one last strobe. It also checks that a fail with the enable low raises no interrupt yet still locks the host out.

// File: rtl/pfts_pkg.sv
package pfts_pkg;

    typedef enum logic [1:0] {
        ADR_RUN   = 2'd0,
        ADR_MODE  = 2'd1,
        ADR_TSAVE = 2'd2,
        ADR_IRQCL = 2'd3
    } reg_adr_e;

    typedef struct packed {
        logic run;
        logic mode;
        logic tsave;
        logic irqcl;
    } wr_hit_t;

    function automatic wr_hit_t decode_wr(input logic en, input logic locked,
                                          input logic [1:0] adr);
        wr_hit_t h;
        logic    ok;
        ok      = en & ~locked;
        h.run   = ok & (adr == ADR_RUN);
        h.mode  = ok & (adr == ADR_MODE);
        h.tsave = ok & (adr == ADR_TSAVE);
        h.irqcl = ok & (adr == ADR_IRQCL);
        return h;
    endfunction

endpackage

// File: rtl/pfts_lockout.sv
module pfts_lockout #(
    parameter int CNT_W    = 6,
    parameter int MIN_HOLD = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fail_cond,
    input  logic             sec_tick,
    input  logic [CNT_W-1:0] hold_len,
    output logic             lockout
);
    localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_HOLD);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = (hold_len < MIN_L) ? MIN_L : hold_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            lockout <= 1'b1;
            cnt     <= '0;
        end else if (fail_cond) begin
            lockout <= 1'b1;
            cnt     <= '0;
        end else if (lockout && sec_tick) begin
            if (cnt == limit - 1'b1) begin
                lockout <= 1'b0;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfts_status.sv
module pfts_status (
    input  logic clk,
    input  logic rst,
    input  logic hit_run,
    input  logic hit_mode,
    input  logic hit_irqcl,
    input  logic wr_val,
    input  logic on_battery,
    input  logic batt_low_cmp,
    input  logic irq_en,
    input  logic fail_cond,
    output logic osc_fail,
    output logic clk_run,
    output logic single_supply,
    output logic low_batt,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            osc_fail      <= 1'b1;
            clk_run       <= 1'b0;
            single_supply <= 1'b1;
            low_batt      <= 1'b0;
            irq           <= 1'b0;
        end else begin
            if (hit_run) begin
                clk_run <= wr_val;
                if (wr_val) osc_fail <= 1'b0;
            end
            if (hit_mode) single_supply <= wr_val;
            low_batt <= on_battery & batt_low_cmp & irq_en;
            if (fail_cond && irq_en)      irq <= 1'b1;
            else if (hit_irqcl && wr_val) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/pfts_tsave.sv
module pfts_tsave (
    input  logic clk,
    input  logic rst,
    input  logic hit_tsave,
    input  logic wr_val,
    input  logic on_battery,
    output logic tsave_en,
    output logic save_strobe
);
    logic batt_q;
    logic to_batt;

    assign to_batt = on_battery & ~batt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            batt_q      <= on_battery;
            tsave_en    <= 1'b0;
            save_strobe <= 1'b0;
        end else begin
            batt_q      <= on_battery;
            save_strobe <= tsave_en;
            if (to_batt)        tsave_en <= 1'b0;
            else if (hit_tsave) tsave_en <= wr_val;
        end
    end
endmodule

// File: rtl/pwrfail_timesave.sv
module pwrfail_timesave
    import pfts_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int MIN_HOLD = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_tick,
    input  logic             vcc_good,
    input  logic             on_battery,
    input  logic             ext_fail,
    input  logic             batt_low_cmp,
    input  logic             fail_irq_en,
    input  logic [CNT_W-1:0] debounce_len,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic             wr_val,
    output logic             osc_fail,
    output logic             clk_run,
    output logic             single_supply,
    output logic             low_batt,
    output logic             irq,
    output logic             lockout,
    output logic             tsave_en,
    output logic             save_strobe
);
    logic    fail_cond;
    wr_hit_t hit;

    assign fail_cond = ext_fail | ~vcc_good;
    assign hit       = decode_wr(wr_en, lockout, wr_addr);

    pfts_lockout #(.CNT_W(CNT_W), .MIN_HOLD(MIN_HOLD)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .fail_cond(fail_cond),
        .sec_tick (sec_tick),
        .hold_len (debounce_len),
        .lockout  (lockout)
    );

    pfts_status u_stat (
        .clk          (clk),
        .rst          (rst),
        .hit_run      (hit.run),
        .hit_mode     (hit.mode),
        .hit_irqcl    (hit.irqcl),
        .wr_val       (wr_val),
        .on_battery   (on_battery),
        .batt_low_cmp (batt_low_cmp),
        .irq_en       (fail_irq_en),
        .fail_cond    (fail_cond),
        .osc_fail     (osc_fail),
        .clk_run      (clk_run),
        .single_supply(single_supply),
        .low_batt     (low_batt),
        .irq          (irq)
    );

    pfts_tsave u_tsave (
        .clk        (clk),
        .rst        (rst),
        .hit_tsave  (hit.tsave),
        .wr_val     (wr_val),
        .on_battery (on_battery),
        .tsave_en   (tsave_en),
        .save_strobe(save_strobe)
    );
endmodule

// File: rtl/pfts_checker.sv
module pfts_checker (
    input logic       clk,
    input logic       rst,
    input logic       vcc_good,
    input logic       on_battery,
    input logic       ext_fail,
    input logic       batt_low_cmp,
    input logic       fail_irq_en,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       wr_val,
    input logic       osc_fail,
    input logic       clk_run,
    input logic       single_supply,
    input logic       low_batt,
    input logic       irq,
    input logic       lockout,
    input logic       tsave_en,
    input logic       save_strobe
);
    AST_OSC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (osc_fail && !(wr_en && !lockout && wr_addr == 2'd0 && wr_val)) |=> osc_fail); // R2
    AST_OSC_NO_RESET: assert property (@(posedge clk) disable iff (rst)
        !osc_fail |=> !osc_fail); // R2
    AST_MODE_KEEPS_OSC: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1) |=> osc_fail == $past(osc_fail)); // R3
    AST_LOWBATT_GATE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> low_batt == $past(on_battery && batt_low_cmp && fail_irq_en)); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && !lockout && wr_addr == 2'd3 && wr_val)) |=> irq); // R5
    AST_IRQ_NO_EN: assert property (@(posedge clk) disable iff (rst)
        (!irq && !fail_irq_en) |=> !irq); // R5
    AST_LOCK_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
        (ext_fail || !vcc_good) |=> lockout); // R6
    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lockout |=> ($stable(clk_run) && $stable(single_supply) && !$rose(tsave_en))); // R8
    AST_TSAVE_BATT: assert property (@(posedge clk) disable iff (rst)
        $rose(on_battery) |=> !tsave_en); // R10
    AST_STROBE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> save_strobe == $past(tsave_en)); // R11
endmodule

bind pwrfail_timesave pfts_checker u_chk (.*);

// File: tb/tb_pwrfail_timesave.sv
module tb_pwrfail_timesave;
    logic       clk = 1'b0;
    logic       rst, sec_tick, vcc_good, on_battery, ext_fail, batt_low_cmp, fail_irq_en;
    logic [5:0] debounce_len;
    logic       wr_en, wr_val;
    logic [1:0] wr_addr;
    logic       osc_fail, clk_run, single_supply, low_batt, irq, lockout, tsave_en, save_strobe;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    pwrfail_timesave dut (.*);

    // {on_battery, batt_low_cmp, fail_irq_en, expected low_batt}
    localparam logic [3:0] LB_VEC [0:7] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0110,
        4'b1000, 4'b1010, 4'b1100, 4'b1111
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic v);
        wr_en = 1'b1; wr_addr = a; wr_val = v;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; sec_tick = 0; vcc_good = 1; on_battery = 0; ext_fail = 0;
        batt_low_cmp = 0; fail_irq_en = 1; debounce_len = 6'd0;
        wr_en = 0; wr_addr = 2'd0; wr_val = 0;
        step(); step();
        rst = 0;
        // R1 reset state
        chk("R1 osc_fail", osc_fail, 1'b1);
        chk("R1 clk_run", clk_run, 1'b0);
        chk("R1 single_supply", single_supply, 1'b1);
        chk("R1 low_batt", low_batt, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 lockout", lockout, 1'b1);
        chk("R1 tsave_en", tsave_en, 1'b0);
        chk("R1 save_strobe", save_strobe, 1'b0);

        // R8 start write while locked is dropped
        wr(2'd0, 1'b1);
        chk("R8 osc_fail kept", osc_fail, 1'b1);
        chk("R8 clk_run kept", clk_run, 1'b0);

        // R7 length 0 raised to 30
        sec_tick = 1;
        repeat (29) step();
        chk("R7 lock at 29", lockout, 1'b1);
        step();
        chk("R7 release at 30", lockout, 1'b0);
        sec_tick = 0;

        // R4 table walk
        for (int i = 0; i < 8; i++) begin
            {on_battery, batt_low_cmp, fail_irq_en} = LB_VEC[i][3:1];
            step();
            chk("R4 low_batt", low_batt, LB_VEC[i][0]);
        end
        on_battery = 0; batt_low_cmp = 0; fail_irq_en = 1;
        step();
        chk("R4 low_batt idle", low_batt, 1'b0);

        // R3 mode writes leave osc_fail alone
        wr(2'd1, 1'b0);
        chk("R3 single_supply 0", single_supply, 1'b0);
        chk("R3 osc_fail kept", osc_fail, 1'b1);
        wr(2'd1, 1'b1);
        chk("R3 single_supply 1", single_supply, 1'b1);

        // R2 start bit
        wr(2'd0, 1'b0);
        chk("R2 osc_fail on zero start", osc_fail, 1'b1);
        chk("R2 clk_run 0", clk_run, 1'b0);
        wr(2'd0, 1'b1);
        chk("R2 osc_fail cleared", osc_fail, 1'b0);
        chk("R2 clk_run 1", clk_run, 1'b1);
        wr(2'd0, 1'b0);
        chk("R2 clk_run stop", clk_run, 1'b0);
        chk("R2 osc_fail stays 0", osc_fail, 1'b0);

        // R9 / R11 enable and strobe
        wr(2'd2, 1'b1);
        chk("R9 tsave set", tsave_en, 1'b1);
        chk("R11 strobe lags", save_strobe, 1'b0);
        step();
        chk("R11 strobe on", save_strobe, 1'b1);
        wr(2'd2, 1'b0);
        chk("R9 tsave clear", tsave_en, 1'b0);
        chk("R11 strobe last", save_strobe, 1'b1);
        step();
        chk("R11 strobe off", save_strobe, 1'b0);

        // R10 / R6 / R5 fail pin does not clear tsave
        wr(2'd2, 1'b1);
        ext_fail = 1;
        step();
        chk("R6 lockout on pin", lockout, 1'b1);
        chk("R10 tsave kept on pin", tsave_en, 1'b1);
        chk("R5 irq set", irq, 1'b1);
        ext_fail = 0;
        on_battery = 1;
        step();
        chk("R10 tsave auto clear", tsave_en, 1'b0);
        chk("R11 final snapshot", save_strobe, 1'b1);
        step();
        chk("R11 strobe after switch", save_strobe, 1'b0);
        wr(2'd3, 1'b1);
        chk("R8 irq clear dropped", irq, 1'b1);
        on_battery = 0;

        // R7 length 40
        debounce_len = 6'd40;
        sec_tick = 1;
        repeat (39) step();
        chk("R7 lock at 39", lockout, 1'b1);
        step();
        chk("R7 release at 40", lockout, 1'b0);
        sec_tick = 0;
        chk("R5 irq held", irq, 1'b1);
        wr(2'd3, 1'b1);
        chk("R5 irq cleared", irq, 1'b0);

        // R6 / R5 fail with enable low
        fail_irq_en = 0;
        vcc_good = 0;
        step();
        chk("R6 lockout enable low", lockout, 1'b1);
        chk("R5 no irq enable low", irq, 1'b0);
        vcc_good = 1;
        debounce_len = 6'd63;
        sec_tick = 1;
        repeat (62) step();
        chk("R7 lock at 62", lockout, 1'b1);
        step();
        chk("R7 release at 63", lockout, 1'b0);
        sec_tick = 0;
        chk("R5 irq still low", irq, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule